// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD registers: seconds, minutes, hours, day of month, month, two-digit year and a 3-bit weekday. A single-cycle strobe `tick_1s`, produced elsewhere once per second, advances the whole set. The carries run through minutes, hours, date and month into year within the same clock edge. The hour register holds its own format control. Its top bit chooses 24-hour counting. With that bit clear the block counts hours 12, 1, … 11 and keeps a PM flag inside the same byte.

Software sets any field through a one-field-per-cycle write port (`wr_en`, `wr_sel`, `wr_data`). All seven fields can be read at all times on dedicated outputs. No field check is made on writes. The calendar applies a plain divisible-by-four leap rule to the two-digit year, so year 00 is a leap year.

The hour logic decodes the stored byte into one of three named states: `MODE_12_AM`, `MODE_12_PM` and `MODE_24`. The transitions are taken on an hour step. `MODE_12_AM` goes to `MODE_12_PM` on 11→12. `MODE_12_PM` goes to `MODE_12_AM` on 11→12, and this transition ends the day. `MODE_24` stays in `MODE_24`, and its 23→00 step ends the day. A write to the hour register can move the state to any of the three.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: Seconds and minutes count in packed BCD 00..59. The low digit carries into the high digit after 9. A step from 59 returns to 00 and steps the next field in the same edge.
- R2: A field changes only on an edge where `tick_1s` is high or where that field is written. A write (wr_sel 0=sec, 1=min, 2=hour, 3=date, 4=month, 5=year, 6=weekday) loads `wr_data` on its own edge, taking priority over any count of that field.
- R3: When hour bit 7 is 0 (12-hour form), bits 4:0 hold BCD 01..12 and bit 5 is the PM flag (1 = PM). The sequence is 12,01,…,11,12. The flag toggles on 11→12, and 11 PM→12 AM ends the day.
- R4: When hour bit 7 is 1 (24-hour form), bits 5:0 count BCD 00..23 with bit 7 kept at 1. The step 23→00 ends the day.
- R5: At the end of a day the date advances. After the last day of the month it returns to 01 and the month advances in BCD. Months 04, 06, 09 and 11 have 30 days, February has 28 or 29, and the others have 31.
- R6: The weekday (3 bits) advances by one at each day end and wraps from 6 to 0.
- R7: February has 29 days when the two-digit year value is divisible by 4, year 00 included, and 28 days otherwise.
- R8: When December 31 ends, the month returns to 01 and the year advances in BCD, wrapping from 99 to 00.
- R9: After reset: seconds 00, minutes 00, hour 0x12 (12-hour form, AM), date 01, month 01, year 00, weekday 0.
- R10: A seconds write on an edge where `tick_1s` is also high stores the written value, and that tick has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle strobe, one per second |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Value written to the selected field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour register: bit 7 format, bit 5 PM flag in 12-hour form |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| wday_o | output | 3 | Day of week 0..6 |

## Verification
The hardest cases to reach are the rare carry chains: the turn of a year, February 28 or 29 in leap and non-leap years, and 11:59:59 PM in 12-hour form. Counting up to them from reset would take millions of ticks. The bench instead uses the write port to load every field just before such a boundary, then gives one tick and compares all seven fields. It also puts a seconds write and a tick on the same edge while the seconds sit at 59, to show the tick leaves no trace.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELD_W = 8;
    localparam int WDAY_W  = 3;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_DATE = 3'd3,
        SEL_MON  = 3'd4,
        SEL_YEAR = 3'd5,
        SEL_WDAY = 3'd6
    } field_sel_e;

    typedef enum logic [1:0] {
        MODE_12_AM = 2'd0,
        MODE_12_PM = 2'd1,
        MODE_24    = 2'd2
    } hour_mode_e;

    // Add one to a two-digit packed BCD value.
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on the two-digit value only (no century rule).
    function automatic logic yr_is_leap(input logic [FIELD_W-1:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    // Last day number, in BCD, of a month.
    function automatic logic [FIELD_W-1:0] last_day(input logic [FIELD_W-1:0] mon,
                                                   input logic [FIELD_W-1:0] y);
        case (mon)
            8'h02:                      return yr_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter
    import rtc_cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] TOP_VAL = 8'h59
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    output logic [FIELD_W-1:0] value,
    output logic               carry
);

    logic [FIELD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (step)  cnt_q <= (cnt_q == TOP_VAL) ? '0 : bcd_inc(cnt_q);
    end

    always_comb begin
        value = cnt_q;
        carry = step && (cnt_q == TOP_VAL);
    end

endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    output logic [FIELD_W-1:0] value,
    output logic               day_end
);

    logic [FIELD_W-1:0] hr_q;
    logic [FIELD_W-1:0] hr_next;
    logic [4:0]         h12;
    logic               wrap_day;
    hour_mode_e         mode;

    // Decode the stored byte into its format state.
    always_comb begin
        if (hr_q[7])      mode = MODE_24;
        else if (hr_q[5]) mode = MODE_12_PM;
        else              mode = MODE_12_AM;
    end

    // Next hour value and day-end flag for one hour step.
    always_comb begin
        h12      = hr_q[4:0];
        hr_next  = hr_q;
        wrap_day = 1'b0;
        unique case (mode)
            MODE_24: begin
                if (hr_q[5:0] == 6'h23) begin
                    hr_next  = 8'h80;
                    wrap_day = 1'b1;
                end else begin
                    hr_next  = {2'b10, 6'(bcd_inc({2'b00, hr_q[5:0]}))};
                end
            end
            MODE_12_AM, MODE_12_PM: begin
                if (h12 == 5'h12) begin
                    hr_next = {2'b00, hr_q[5], 5'h01};
                end else if (h12 == 5'h11) begin
                    hr_next  = {2'b00, (mode == MODE_12_AM), 5'h12};
                    wrap_day = (mode == MODE_12_PM);
                end else begin
                    hr_next = {2'b00, hr_q[5], 5'(bcd_inc({3'b000, h12}))};
                end
            end
            default: hr_next = hr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hr_q <= 8'h12;
        else if (load)  hr_q <= load_val;
        else if (step)  hr_q <= hr_next;
    end

    always_comb begin
        value   = hr_q;
        day_end = step && wrap_day;
    end

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               load_date,
    input  logic               load_mon,
    input  logic               load_year,
    input  logic               load_wday,
    input  logic [FIELD_W-1:0] load_val,
    output logic [FIELD_W-1:0] date,
    output logic [FIELD_W-1:0] month,
    output logic [FIELD_W-1:0] year,
    output logic [WDAY_W-1:0]  wday
);

    localparam logic [WDAY_W-1:0] WDAY_LAST = WDAY_W'(6);

    logic [FIELD_W-1:0] date_q, mon_q, year_q;
    logic [WDAY_W-1:0]  wday_q;
    logic               month_end, year_end;

    always_comb begin
        month_end = step && (date_q == last_day(mon_q, year_q));
        year_end  = month_end && (mon_q == 8'h12);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            date_q <= 8'h01;
            mon_q  <= 8'h01;
            year_q <= 8'h00;
            wday_q <= '0;
        end else begin
            if (load_date)      date_q <= load_val;
            else if (month_end) date_q <= 8'h01;
            else if (step)      date_q <= bcd_inc(date_q);

            if (load_mon)       mon_q <= load_val;
            else if (year_end)  mon_q <= 8'h01;
            else if (month_end) mon_q <= bcd_inc(mon_q);

            if (load_year)      year_q <= load_val;
            else if (year_end)  year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);

            if (load_wday)      wday_q <= load_val[WDAY_W-1:0];
            else if (step)      wday_q <= (wday_q >= WDAY_LAST) ? '0 : wday_q + 1'b1;
        end
    end

    always_comb begin
        date  = date_q;
        month = mon_q;
        year  = year_q;
        wday  = wday_q;
    end

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1s,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic [FIELD_W-1:0] date_o,
    output logic [FIELD_W-1:0] month_o,
    output logic [FIELD_W-1:0] year_o,
    output logic [WDAY_W-1:0]  wday_o
);

    localparam int N_SEL = 7;

    logic [N_SEL-1:0] ld;
    logic             tick_eff;
    logic             sec_carry, min_carry, day_end, unused_carry;

    // One load strobe per field.
    for (genvar g = 0; g < N_SEL; g++) begin : g_ld
        assign ld[g] = wr_en && (wr_sel == SEL_W'(g));
    end

    // A seconds write swallows a tick on the same edge.
    assign tick_eff = tick_1s && !ld[SEL_SEC];

    rtc_mod_counter #(.TOP_VAL(8'h59)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(tick_eff),
        .load(ld[SEL_SEC]), .load_val(wr_data),
        .value(sec_o), .carry(sec_carry)
    );

    rtc_mod_counter #(.TOP_VAL(8'h59)) u_min (
        .clk(clk), .rst_n(rst_n), .step(sec_carry),
        .load(ld[SEL_MIN]), .load_val(wr_data),
        .value(min_o), .carry(min_carry)
    );

    rtc_hour_counter u_hour (
        .clk(clk), .rst_n(rst_n), .step(min_carry),
        .load(ld[SEL_HOUR]), .load_val(wr_data),
        .value(hour_o), .day_end(day_end)
    );

    rtc_date_counter u_cal (
        .clk(clk), .rst_n(rst_n), .step(day_end),
        .load_date(ld[SEL_DATE]), .load_mon(ld[SEL_MON]),
        .load_year(ld[SEL_YEAR]), .load_wday(ld[SEL_WDAY]),
        .load_val(wr_data),
        .date(date_o), .month(month_o), .year(year_o), .wday(wday_o)
    );

    assign unused_carry = 1'b0;

endmodule

// File: rtl/bcd_rtc_calendar_chk.sv
module bcd_rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tick_1s,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [FIELD_W-1:0] wr_data,
    input logic [FIELD_W-1:0] sec_o,
    input logic [FIELD_W-1:0] min_o,
    input logic [FIELD_W-1:0] hour_o,
    input logic [FIELD_W-1:0] date_o,
    input logic [FIELD_W-1:0] month_o,
    input logic [FIELD_W-1:0] year_o,
    input logic [WDAY_W-1:0]  wday_o
);

    logic top_of_hour;
    assign top_of_hour = tick_1s && !wr_en && sec_o == 8'h59 && min_o == 8'h59;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1s && !wr_en && sec_o == 8'h59) |=> (sec_o == 8'h00)) else $error("sec wrap"); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1s && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
            && $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(wday_o)))
        else $error("hold"); // R2

    AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (top_of_hour && !hour_o[7] && hour_o[4:0] == 5'h11)
        |=> (hour_o[5] != $past(hour_o[5]) && hour_o[4:0] == 5'h12)) else $error("pm"); // R3

    AST_H24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (top_of_hour && hour_o == 8'hA3) |=> (hour_o == 8'h80)) else $error("h24"); // R4

    AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (top_of_hour && hour_o == 8'hA3)
        |=> (wday_o == (($past(wday_o) >= 3'd6) ? 3'd0 : $past(wday_o) + 3'd1))) else $error("wday"); // R6

    AST_SEC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SEC) |=> (sec_o == $past(wr_data) && $stable(min_o)))
        else $error("sec write"); // R10

endmodule

bind bcd_rtc_calendar bcd_rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o)
);

// File: tb/bcd_rtc_calendar_tb.sv
module bcd_rtc_calendar_tb;

    localparam int NV = 19;
    localparam int VW = 51;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] wday_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o)
    );

    // {preset sec,min,hour,date,month,year,wday} then {expected after one tick}
    localparam logic [2*VW-1:0] VEC [NV] = '{
        {8'h09,8'h00,8'h80,8'h01,8'h01,8'h24,3'd0, 8'h10,8'h00,8'h80,8'h01,8'h01,8'h24,3'd0}, // R1
        {8'h59,8'h09,8'h80,8'h01,8'h01,8'h24,3'd0, 8'h00,8'h10,8'h80,8'h01,8'h01,8'h24,3'd0}, // R1
        {8'h59,8'h59,8'h89,8'h01,8'h01,8'h24,3'd0, 8'h00,8'h00,8'h90,8'h01,8'h01,8'h24,3'd0}, // R4
        {8'h59,8'h59,8'hA3,8'h15,8'h06,8'h24,3'd3, 8'h00,8'h00,8'h80,8'h16,8'h06,8'h24,3'd4}, // R4
        {8'h59,8'h59,8'hA3,8'h30,8'h04,8'h23,3'd6, 8'h00,8'h00,8'h80,8'h01,8'h05,8'h23,3'd0}, // R6
        {8'h59,8'h59,8'hA3,8'h31,8'h01,8'h23,3'd1, 8'h00,8'h00,8'h80,8'h01,8'h02,8'h23,3'd2}, // R5
        {8'h59,8'h59,8'hA3,8'h30,8'h09,8'h25,3'd0, 8'h00,8'h00,8'h80,8'h01,8'h10,8'h25,3'd1}, // R5
        {8'h59,8'h59,8'hA3,8'h30,8'h07,8'h25,3'd0, 8'h00,8'h00,8'h80,8'h31,8'h07,8'h25,3'd1}, // R5
        {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h23,3'd2, 8'h00,8'h00,8'h80,8'h01,8'h03,8'h23,3'd3}, // R7
        {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h24,3'd2, 8'h00,8'h00,8'h80,8'h29,8'h02,8'h24,3'd3}, // R7
        {8'h59,8'h59,8'hA3,8'h29,8'h02,8'h24,3'd3, 8'h00,8'h00,8'h80,8'h01,8'h03,8'h24,3'd4}, // R7
        {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h00,3'd5, 8'h00,8'h00,8'h80,8'h29,8'h02,8'h00,3'd6}, // R7
        {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h10,3'd0, 8'h00,8'h00,8'h80,8'h01,8'h03,8'h10,3'd1}, // R7
        {8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd4, 8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,3'd5}, // R8
        {8'h59,8'h59,8'h11,8'h10,8'h03,8'h25,3'd1, 8'h00,8'h00,8'h32,8'h10,8'h03,8'h25,3'd1}, // R3
        {8'h59,8'h59,8'h31,8'h10,8'h03,8'h25,3'd1, 8'h00,8'h00,8'h12,8'h11,8'h03,8'h25,3'd2}, // R3
        {8'h59,8'h59,8'h32,8'h10,8'h03,8'h25,3'd1, 8'h00,8'h00,8'h21,8'h10,8'h03,8'h25,3'd1}, // R3
        {8'h59,8'h59,8'h12,8'h10,8'h03,8'h25,3'd1, 8'h00,8'h00,8'h01,8'h10,8'h03,8'h25,3'd1}, // R3
        {8'h59,8'h59,8'h09,8'h10,8'h03,8'h25,3'd1, 8'h00,8'h00,8'h10,8'h10,8'h03,8'h25,3'd1}  // R3
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1:          return "R1";
            2, 3:          return "R4";
            4:             return "R6";
            5, 6, 7:       return "R5";
            8, 9, 10, 11, 12: return "R7";
            13:            return "R8";
            default:       return "R3";
        endcase
    endfunction

    function automatic logic [VW-1:0] snap();
        return {sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o};
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d, input logic with_tick);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_1s = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick_1s = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic preset(input logic [VW-1:0] p);
        wr(3'd0, p[50:43], 1'b0);
        wr(3'd1, p[42:35], 1'b0);
        wr(3'd2, p[34:27], 1'b0);
        wr(3'd3, p[26:19], 1'b0);
        wr(3'd4, p[18:11], 1'b0);
        wr(3'd5, p[10:3],  1'b0);
        wr(3'd6, {5'd0, p[2:0]}, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9", snap(), {8'h00,8'h00,8'h12,8'h01,8'h01,8'h00,3'd0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", snap(), {8'h00,8'h00,8'h12,8'h01,8'h01,8'h00,3'd0});

        for (int i = 0; i < NV; i++) begin
            preset(VEC[i][2*VW-1:VW]);
            check("R2", snap(), VEC[i][2*VW-1:VW]);
            tick();
            check(vec_req(i), snap(), VEC[i][VW-1:0]);
        end

        // R2: no tick, no write -> nothing moves
        preset({8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6});
        repeat (6) @(negedge clk);
        check("R2", snap(), {8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6});

        // R10: seconds write with tick on same edge, seconds at 59
        wr(3'd0, 8'h30, 1'b1);
        check("R10", snap(), {8'h30,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6});

        // R2: minute write with tick on same edge; seconds still advance
        wr(3'd1, 8'h05, 1'b1);
        check("R2", snap(), {8'h31,8'h05,8'hA3,8'h31,8'h12,8'h99,3'd6});

        // R1: 60 ticks from 00:00 give one minute
        preset({8'h00,8'h00,8'h80,8'h01,8'h01,8'h24,3'd0});
        for (int k = 0; k < 60; k++) tick();
        check("R1", snap(), {8'h00,8'h01,8'h80,8'h01,8'h01,8'h24,3'd0});

        // R9: reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", snap(), {8'h00,8'h00,8'h12,8'h01,8'h01,8'h00,3'd0});
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule